// File: doc/BRIEF.md
# Chopping Current Regulator PWM Controller

This block runs fixed-frequency current chopping for one winding of an H-bridge. Each PWM period begins with the bridge driving current in the selected direction. The external sense comparator is ignored for a blanking window after the period starts. Once the comparator trips after that window, the bridge switches to a decay pattern and keeps it until the next period begins. Three decay styles are available:

- **Slow:** both low-side FETs are on, so the winding current recirculates.
- **Fast:** the bridge is reversed, and all FETs turn off once the near-zero flag rises.
- **Mixed:** fast decay until the three-quarter point of the period, then slow decay for the rest of it.

The outputs are the four FET gate enables, registered, plus the scaled reference percentage for the external DAC. The current code, direction and decay select are captured only at a period boundary. The enable input acts at once.

Period, blanking and three-quarter point are counts of clock cycles. They are derived from a clock-frequency parameter, a PWM-frequency parameter and a blanking time in nanoseconds.

Top module: `chop_pwm_ctrl`

## Requirements
- R1: Periods are PER clock cycles long. Period index 0 falls on the first clock edge after reset release, and the index steps by one each cycle. From index 0 the internal state drives: direction 1 gives OUT1 high (hs1, ls2 on) and direction 0 gives OUT2 high (hs2, ls1 on).
- R2: The trip input is ignored while the period index is below BLANK. So drive lasts at least BLANK+1 cycles.
- R3: A trip seen at index BLANK or later moves the state to decay on the next cycle. It stays in decay until the next period starts, whatever trip does afterwards.
- R4: Slow decay turns on ls1 and ls2 only.
- R5: Fast decay drives the reversed direction. The near-zero flag during fast decay turns all four FETs off for the rest of the period.
- R6: In mixed decay the state begins as fast. From index MIX = 3·PER/4 onward it is slow, whether it was fast or already off.
- R7: When en is low, all four gate outputs are low one cycle later. The enable is not latched at period boundaries.
- R8: pct shows the percentage for the captured 5-bit code: 0,5,10,15,20,24,29,34,38,43,47,51,56,60,63,67,71,74,77,80,83,86,88,90,92,94,96,97,98,99,100,100 for codes 0 to 31.
- R9: The decay select is decoded as 00 slow, 01 mixed, 10 fast, 11 slow.
- R10: Gate outputs are registered one cycle after the state. No leg ever has both FETs on. A leg that changes from one FET on to a different pattern spends one cycle with both off first.
- R11: Current code, direction and decay select are captured only at the start of a period. A change in the middle of a period has no effect until the next one.
- R12: During reset and up to the first period start, all gates and pct are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Bridge enable |
| phase | input | 1 | Drive direction |
| cur_code | input | 5 | Current level code |
| decay_sel | input | 2 | Decay style select |
| trip | input | 1 | Sense comparator tripped |
| near_zero | input | 1 | Winding current near zero |
| pct | output | 7 | Reference percentage for DAC |
| hs1 | output | 1 | Leg 1 high-side enable |
| ls1 | output | 1 | Leg 1 low-side enable |
| hs2 | output | 1 | Leg 2 high-side enable |
| ls2 | output | 1 | Leg 2 low-side enable |

## Verification
The bench varies the trip input in three ways:

- **Trip never asserted:** the bridge drives for the whole period.
- **Trip held high from the period start:** this exposes the blanking length.
- **Trip pulsed late:** this shows that decay is held until the period ends.

Each decay style, including the 11 alias, is run with and without the near-zero flag. This separates fast-to-off from mixed-to-slow around the three-quarter point. Two further patterns check the direction handling and the capture rule:

- Direction flips every period and mid-period changes to the code and direction are applied, to check capture at the boundary and the dead cycles on each leg.
- A sweep of all 32 codes checks the percentage table.

// File: rtl/chop_pwm_ctrl.sv
module chop_pwm_ctrl #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int PWM_HZ   = 50_000,
  parameter int BLANK_NS = 3750
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       phase,
  input  logic [4:0] cur_code,
  input  logic [1:0] decay_sel,
  input  logic       trip,
  input  logic       near_zero,
  output logic [6:0] pct,
  output logic       hs1,
  output logic       ls1,
  output logic       hs2,
  output logic       ls2
);
  localparam int PER   = CLK_HZ / PWM_HZ;
  localparam int BLANK = (CLK_HZ / 1_000_000) * BLANK_NS / 1000;
  localparam int MIX   = (PER * 3) / 4;
  localparam int CW    = $clog2(PER);

  typedef enum logic [1:0] {M_DRIVE, M_FAST, M_SLOW, M_OFF} mode_t;

  logic [CW-1:0] cnt;
  mode_t         mode;
  logic          ph_q;
  logic [4:0]    code_q;
  logic [1:0]    dec_q;
  logic [3:0]    want, gate;

  wire last    = (cnt == CW'(PER - 1));
  wire blanked = (cnt < CW'(BLANK));
  wire past75  = (cnt >= CW'(MIX - 1));
  wire mixed   = (dec_q == 2'b01);
  wire fast    = (dec_q == 2'b10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= CW'(PER - 1);
      mode   <= M_OFF;
      ph_q   <= 1'b0;
      code_q <= '0;
      dec_q  <= '0;
    end else if (last) begin
      cnt    <= '0;
      mode   <= M_DRIVE;
      ph_q   <= phase;
      code_q <= cur_code;
      dec_q  <= decay_sel;
    end else begin
      cnt <= cnt + 1'b1;
      unique case (mode)
        M_DRIVE: if (!blanked && trip) mode <= (mixed || fast) ? M_FAST : M_SLOW;
        M_FAST:  if (mixed && past75) mode <= M_SLOW;
                 else if (near_zero) mode <= M_OFF;
        M_OFF:   if (mixed && past75) mode <= M_SLOW;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (mode)
      M_DRIVE: want = ph_q ? 4'b1001 : 4'b0110;
      M_FAST:  want = ph_q ? 4'b0110 : 4'b1001;
      M_SLOW:  want = 4'b0101;
      default: want = 4'b0000;
    endcase
    if (!en) want = 4'b0000;
  end

  function automatic logic [1:0] leg_next(input logic [1:0] cur, input logic [1:0] tgt);
    return (cur != 2'b00 && cur != tgt) ? 2'b00 : tgt;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate <= '0;
    else        gate <= {leg_next(gate[3:2], want[3:2]), leg_next(gate[1:0], want[1:0])};
  end

  assign {hs1, ls1, hs2, ls2} = gate;

  always_comb begin
    unique case (code_q)
      5'd0:  pct = 7'd0;   5'd1:  pct = 7'd5;   5'd2:  pct = 7'd10;  5'd3:  pct = 7'd15;
      5'd4:  pct = 7'd20;  5'd5:  pct = 7'd24;  5'd6:  pct = 7'd29;  5'd7:  pct = 7'd34;
      5'd8:  pct = 7'd38;  5'd9:  pct = 7'd43;  5'd10: pct = 7'd47;  5'd11: pct = 7'd51;
      5'd12: pct = 7'd56;  5'd13: pct = 7'd60;  5'd14: pct = 7'd63;  5'd15: pct = 7'd67;
      5'd16: pct = 7'd71;  5'd17: pct = 7'd74;  5'd18: pct = 7'd77;  5'd19: pct = 7'd80;
      5'd20: pct = 7'd83;  5'd21: pct = 7'd86;  5'd22: pct = 7'd88;  5'd23: pct = 7'd90;
      5'd24: pct = 7'd92;  5'd25: pct = 7'd94;  5'd26: pct = 7'd96;  5'd27: pct = 7'd97;
      5'd28: pct = 7'd98;  5'd29: pct = 7'd99;  default: pct = 7'd100;
    endcase
  end

  AST_LEG1_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(hs1 && ls1)); // R10
  AST_LEG2_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(hs2 && ls2)); // R10
  AST_DEAD_HS1: assert property (@(posedge clk) disable iff (!rst_n) hs1 |=> !ls1); // R10
  AST_DEAD_LS1: assert property (@(posedge clk) disable iff (!rst_n) ls1 |=> !hs1); // R10
  AST_DEAD_HS2: assert property (@(posedge clk) disable iff (!rst_n) hs2 |=> !ls2); // R10
  AST_DEAD_LS2: assert property (@(posedge clk) disable iff (!rst_n) ls2 |=> !hs2); // R10
  AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !(hs1 || ls1 || hs2 || ls2)); // R7
  AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mode == M_DRIVE && blanked) |=> mode == M_DRIVE); // R2
  AST_DECAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mode != M_DRIVE && !last) |=> mode != M_DRIVE); // R3
  AST_CAPTURE_EDGE: assert property (@(posedge clk) disable iff (!rst_n) !last |=> ($stable(code_q) && $stable(ph_q) && $stable(dec_q))); // R11
  AST_PCT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) pct <= 7'd100); // R8
endmodule

// File: tb/sim_chop_pwm_ctrl.sv
module sim_chop_pwm_ctrl;
  localparam int PER = 100, BL = 15, MX = 75;
  localparam int D = 0, F = 1, S = 2, O = 3;

  logic clk = 0, rst_n = 0, en = 0, phase = 0, trip = 0, near_zero = 0;
  logic [4:0] cur_code = 0;
  logic [1:0] decay_sel = 0;
  logic [6:0] pct;
  logic hs1, ls1, hs2, ls2;

  chop_pwm_ctrl #(.CLK_HZ(100_000_000), .PWM_HZ(1_000_000), .BLANK_NS(150)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .phase(phase), .cur_code(cur_code),
    .decay_sel(decay_sel), .trip(trip), .near_zero(near_zero), .pct(pct),
    .hs1(hs1), .ls1(ls1), .hs2(hs2), .ls2(ls2));

  always #5 clk = ~clk;

  int tbl[32] = '{0,5,10,15,20,24,29,34,38,43,47,51,56,60,63,67,
                  71,74,77,80,83,86,88,90,92,94,96,97,98,99,100,100};
  int checks = 0, errors = 0;
  string cur_req = "R12";
  int mcnt, md, mph, mcd, mdc;
  logic [3:0] mg, pg;
  bit mstart = 0;

  function automatic logic [1:0] legn(logic [1:0] c, logic [1:0] t);
    if (c != 0 && c != t) return 2'b00;
    return t;
  endfunction

  always @(posedge clk) begin
    logic [3:0] d;
    if (!rst_n) begin
      mcnt = PER - 1; md = O; mph = 0; mcd = 0; mdc = 0; mg = 0;
    end else begin
      if (!en) d = 0;
      else if (md == D) d = mph ? 4'b1001 : 4'b0110;
      else if (md == F) d = mph ? 4'b0110 : 4'b1001;
      else if (md == S) d = 4'b0101;
      else d = 0;
      mg = {legn(mg[3:2], d[3:2]), legn(mg[1:0], d[1:0])};
      if (mcnt == PER - 1) begin
        mcnt = 0; md = D; mph = phase; mcd = cur_code; mdc = decay_sel;
      end else begin
        if (md == D && mcnt >= BL && trip) md = (mdc == 1 || mdc == 2) ? F : S;
        else if ((md == F || md == O) && mdc == 1 && mcnt >= MX - 1) md = S;
        else if (md == F && near_zero) md = O;
        mcnt++;
      end
    end
    mstart = 1;
  end

  task automatic chk(bit c, string tag, int act, int exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (mstart) begin
    logic [3:0] g;
    g = {hs1, ls1, hs2, ls2};
    chk(g == mg, cur_req, g, mg);
    chk(pct == 7'(tbl[mcd]), "R8", pct, tbl[mcd]);
    chk(!((pg[3] && g[2]) || (pg[2] && g[3]) || (pg[1] && g[0]) || (pg[0] && g[1])), "R10", g, pg);
    pg = g;
  end

  task automatic at_idx(int k);
    do @(negedge clk); while (mcnt != k);
  endtask

  task automatic pulse_at(int k, ref logic s);
    at_idx(k); s = 1; @(negedge clk); s = 0;
  endtask

  initial begin
    pg = 0;
    repeat (3) @(negedge clk);
    chk({hs1, ls1, hs2, ls2} == 0 && pct == 0, "R12", {hs1, ls1, hs2, ls2}, 0);
    rst_n = 1;
    cur_req = "R1"; en = 1; phase = 1; cur_code = 5; decay_sel = 0;
    at_idx(0); at_idx(50); chk(hs1 && ls2 && !ls1 && !hs2, "R1", {hs1, ls1, hs2, ls2}, 9);
    at_idx(0);
    cur_req = "R2"; trip = 1; at_idx(0); at_idx(BL);
    chk(hs1 && ls2, "R2", {hs1, ls1, hs2, ls2}, 9); at_idx(0);
    trip = 0; cur_req = "R4"; pulse_at(40, trip); at_idx(0);
    cur_req = "R3"; pulse_at(20, trip); pulse_at(60, near_zero); at_idx(90);
    chk(ls1 && ls2 && !hs1 && !hs2, "R3", {hs1, ls1, hs2, ls2}, 5); at_idx(0);
    cur_req = "R5"; decay_sel = 2; at_idx(0); pulse_at(30, trip); pulse_at(55, near_zero); at_idx(0);
    cur_req = "R6"; decay_sel = 1; at_idx(0); pulse_at(30, trip); at_idx(MX + 3);
    chk(ls1 && ls2, "R6", {hs1, ls1, hs2, ls2}, 5);
    at_idx(0); pulse_at(30, trip); pulse_at(50, near_zero); at_idx(0);
    cur_req = "R9"; decay_sel = 3; at_idx(0); pulse_at(30, trip); at_idx(0);
    cur_req = "R10"; decay_sel = 2;
    for (int i = 0; i < 4; i++) begin phase = ~phase; pulse_at(25, trip); at_idx(0); end
    cur_req = "R11"; cur_code = 9; decay_sel = 0; at_idx(0); at_idx(50);
    phase = 0; cur_code = 31; at_idx(60);
    chk(pct == 7'(tbl[9]), "R11", pct, tbl[9]);
    chk(hs1 && ls2, "R11", {hs1, ls1, hs2, ls2}, 9); at_idx(0); at_idx(5);
    chk(pct == 100 && hs2 && ls1, "R11", pct, 100);
    cur_req = "R7"; en = 0; at_idx(0); at_idx(5);
    chk({hs1, ls1, hs2, ls2} == 0, "R7", {hs1, ls1, hs2, ls2}, 0);
    en = 1; at_idx(10); en = 0; at_idx(12); en = 1; at_idx(0);
    cur_req = "R8";
    for (int c = 0; c < 32; c++) begin
      at_idx(90); cur_code = 5'(c); at_idx(5);
      chk(pct == 7'(tbl[c]), "R8", pct, tbl[c]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule